// File: doc/BRIEF.md
# Split-Path DMA Word Combiner

This block merges two independent byte streams into one word-wide DMA channel for a widened parallel bus. The first stream is a byte-wide path to a protocol controller. The second is a FIFO that carries one extra byte in 16-bit mode or three extra bytes in 32-bit mode. The block raises a single request toward memory only when both paths can take part in a transfer. Which readiness test applies depends on the transfer direction: when data moves toward memory, the FIFO must hold data; when data moves away from memory, the FIFO must have room.

Each memory acknowledge moves one whole word. On inbound transfers the block pops one byte from the controller and one or three bytes from the FIFO, and assembles them into a word. On outbound transfers it splits the memory word into a controller byte and FIFO bytes, adds parity, and pushes them. The acknowledge is also reused as a side-effect strobe for the secondary-cable handshake logic. An initiator that receives data forwards it as the cable acknowledge. A target that receives data turns it into a decrement of its offset counter. Every byte lane carries an odd-parity bit. Parity is generated on the write path and checked on the read path, and a mismatch sets a sticky error flag.

Top module: `dcmb_top`

## Requirements
- R1: With `cfg_dir_in`=1, `mem_req` is high in a cycle only if, at the previous rising edge, `ctl_dreq` was high and `fifo_empty` was low. `fifo_full` has no effect in this direction.
- R2: With `cfg_dir_in`=0, `mem_req` is high in a cycle only if, at the previous rising edge, `ctl_dreq` was high and `fifo_full` was low. `fifo_empty` has no effect in this direction.
- R3: An accepted acknowledge is `mem_ack` high at a rising edge while `mem_req` is high. After an accepted acknowledge, `mem_req` is low for the next two cycles. It then rises again if both readiness conditions still hold.
- R4: In the cycle after an accepted inbound acknowledge, `ctl_pop` and `fifo_pop` pulse for one cycle and `mem_rd_word` holds the assembled word. The controller byte sits in bits 7:0, FIFO lane 0 in bits 15:8, lane 1 in bits 23:16 and lane 2 in bits 31:24. Each 9-bit lane is {odd parity bit, data byte}, and FIFO lane i occupies bits 9i+8 to 9i of the FIFO buses.
- R5: In the cycle after an accepted outbound acknowledge, `ctl_push` and `fifo_push` pulse for one cycle. The lanes carry bytes taken from `mem_wr_word` in the same order as R4. Each lane's bit 8 is set so that the lane holds an odd number of ones.
- R6: With `cfg_wide`=0, FIFO lanes 1 and 2 are unused. `mem_rd_word` bits 31:16 read zero, and outbound FIFO lanes 1 and 2 are driven as all nine bits zero.
- R7: With `cfg_dir_in`=1 and `cfg_role_tgt`=0, each accepted acknowledge gives one `cable_ack` pulse in the following cycle, and `cnt_dec` stays low.
- R8: With `cfg_dir_in`=1 and `cfg_role_tgt`=1, each accepted acknowledge gives one `cnt_dec` pulse in the following cycle, and `cable_ack` stays low. In outbound transfers neither of these pulses is produced.
- R9: `par_err` is set, in the cycle after an accepted inbound acknowledge, when any lane in use has even parity. It then stays set until reset. Lanes that are unused in 16-bit mode are not checked.
- R10: While `rst_n` is low and after reset, `mem_req`, every strobe, `par_err`, `mem_rd_word` and both write lane buses are zero.
- R11: `mem_ack` while `mem_req` is low causes no strobe and changes no output data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wide | input | 1 | 1 = 32-bit word, 0 = 16-bit word (static) |
| cfg_dir_in | input | 1 | 1 = data toward memory, 0 = data from memory (static per transfer) |
| cfg_role_tgt | input | 1 | 1 = target, 0 = initiator |
| ctl_dreq | input | 1 | DMA request from the protocol controller |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_full | input | 1 | FIFO has no room |
| mem_req | output | 1 | Combined DMA request toward memory |
| mem_ack | input | 1 | DMA acknowledge from memory |
| mem_rd_word | output | 32 | Word assembled for memory (inbound) |
| mem_wr_word | input | 32 | Word from memory (outbound) |
| ctl_rd_lane | input | 9 | Controller byte with parity (inbound) |
| ctl_wr_lane | output | 9 | Controller byte with parity (outbound) |
| ctl_pop | output | 1 | Read strobe to the controller |
| ctl_push | output | 1 | Write strobe to the controller |
| fifo_rd_lanes | input | 27 | FIFO output lanes with parity |
| fifo_wr_lanes | output | 27 | FIFO input lanes with parity |
| fifo_pop | output | 1 | FIFO read strobe |
| fifo_push | output | 1 | FIFO write strobe |
| cable_ack | output | 1 | Secondary-cable acknowledge strobe |
| cnt_dec | output | 1 | Offset control counter decrement |
| par_err | output | 1 | Sticky lane parity error |

## Verification
Two functions can fall in the same cycle. The first is the acknowledge of a word. The second is the renewed readiness evaluation that could raise the request again. The bench holds both controller and FIFO ready across each acknowledge. It then expects the request low in exactly the two cycles after the accepted edge and high in the third. In that same window, a scoreboard entry pushed at the acknowledge must match the strobes, lanes, side-effect pulse and parity flag that appear.

// File: rtl/dcmb_pkg.sv
package dcmb_pkg;

    // side effect attached to an accepted acknowledge
    typedef enum logic [1:0] {
        FX_NONE      = 2'd0,
        FX_CABLE_ACK = 2'd1,
        FX_CNT_DEC   = 2'd2
    } ack_fx_e;

    function automatic ack_fx_e fx_select(input logic dir_in, input logic role_tgt);
        if (!dir_in) begin
            return FX_NONE;
        end
        return role_tgt ? FX_CNT_DEC : FX_CABLE_ACK;
    endfunction

endpackage

// File: rtl/dcmb_gate.sv
module dcmb_gate (
    input  logic dir_in,
    input  logic ctl_dreq,
    input  logic fifo_empty,
    input  logic fifo_full,
    output logic ready
);
    logic fifo_ok;

    always_comb begin
        fifo_ok = dir_in ? ~fifo_empty : ~fifo_full;
        ready   = ctl_dreq & fifo_ok;
    end
endmodule

// File: rtl/dcmb_fx.sv
module dcmb_fx
    import dcmb_pkg::*;
(
    input  logic dir_in,
    input  logic role_tgt,
    input  logic accept,
    output logic ctl_pop,
    output logic ctl_push,
    output logic fifo_pop,
    output logic fifo_push,
    output logic cab_ack,
    output logic cnt_dec
);
    ack_fx_e fx;

    always_comb begin
        fx        = fx_select(dir_in, role_tgt);
        ctl_pop   = accept &  dir_in;
        fifo_pop  = accept &  dir_in;
        ctl_push  = accept & ~dir_in;
        fifo_push = accept & ~dir_in;
        cab_ack   = accept & (fx == FX_CABLE_ACK);
        cnt_dec   = accept & (fx == FX_CNT_DEC);
    end
endmodule

// File: rtl/dcmb_lanes.sv
module dcmb_lanes #(
    parameter int unsigned LANE_W = 8,
    parameter int unsigned XLANES = 3,
    localparam int unsigned LW1    = LANE_W + 1,
    localparam int unsigned WORD_W = LANE_W * (XLANES + 1),
    localparam int unsigned XW     = XLANES * LW1
) (
    input  logic              wide,
    input  logic [LW1-1:0]    ctl_rd_lane,
    input  logic [XW-1:0]     fifo_rd_lanes,
    input  logic [WORD_W-1:0] mem_wr_word,
    output logic [WORD_W-1:0] rd_word,
    output logic              rd_perr,
    output logic [LW1-1:0]    ctl_wr_lane,
    output logic [XW-1:0]     fifo_wr_lanes
);
    localparam int unsigned NARROW_X = 1;

    logic              ctl_bad;
    logic [XLANES-1:0] lane_bad;

    // controller lane: word bits LANE_W-1:0
    always_comb begin
        rd_word[LANE_W-1:0] = ctl_rd_lane[LANE_W-1:0];
        ctl_bad             = ~(^ctl_rd_lane);
        ctl_wr_lane         = {~(^mem_wr_word[LANE_W-1:0]), mem_wr_word[LANE_W-1:0]};
    end

    for (genvar gi = 0; gi < XLANES; gi++) begin : g_lane
        logic              used;
        logic [LW1-1:0]    rl;
        logic [LANE_W-1:0] wb;

        always_comb begin
            used = (gi < NARROW_X) ? 1'b1 : wide;
            rl   = fifo_rd_lanes[gi*LW1 +: LW1];
            wb   = mem_wr_word[(gi+1)*LANE_W +: LANE_W];
            rd_word[(gi+1)*LANE_W +: LANE_W] = used ? rl[LANE_W-1:0] : '0;
            lane_bad[gi]                     = used & ~(^rl);
            fifo_wr_lanes[gi*LW1 +: LW1]     = used ? {~(^wb), wb} : '0;
        end
    end

    always_comb rd_perr = ctl_bad | (|lane_bad);
endmodule

// File: rtl/dcmb_top.sv
module dcmb_top #(
    parameter int unsigned LANE_W = 8,
    parameter int unsigned XLANES = 3,
    localparam int unsigned LW1    = LANE_W + 1,
    localparam int unsigned WORD_W = LANE_W * (XLANES + 1),
    localparam int unsigned XW     = XLANES * LW1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wide,
    input  logic              cfg_dir_in,
    input  logic              cfg_role_tgt,
    input  logic              ctl_dreq,
    input  logic              fifo_empty,
    input  logic              fifo_full,
    output logic              mem_req,
    input  logic              mem_ack,
    output logic [WORD_W-1:0] mem_rd_word,
    input  logic [WORD_W-1:0] mem_wr_word,
    input  logic [LW1-1:0]    ctl_rd_lane,
    output logic [LW1-1:0]    ctl_wr_lane,
    output logic              ctl_pop,
    output logic              ctl_push,
    input  logic [XW-1:0]     fifo_rd_lanes,
    output logic [XW-1:0]     fifo_wr_lanes,
    output logic              fifo_pop,
    output logic              fifo_push,
    output logic              cable_ack,
    output logic              cnt_dec,
    output logic              par_err
);
    typedef struct packed {
        logic              req;
        logic              hold;
        logic              ctl_pop;
        logic              ctl_push;
        logic              fifo_pop;
        logic              fifo_push;
        logic              cab;
        logic              dec;
        logic              perr;
        logic [WORD_W-1:0] rd_word;
        logic [LW1-1:0]    ctl_wr;
        logic [XW-1:0]     fifo_wr;
    } st_t;

    st_t st_d, st_q;

    logic              ready_c;
    logic              accept_c;
    logic              fx_ctl_pop, fx_ctl_push, fx_fifo_pop, fx_fifo_push;
    logic              fx_cab, fx_dec;
    logic [WORD_W-1:0] rd_word_c;
    logic              rd_perr_c;
    logic [LW1-1:0]    ctl_wr_c;
    logic [XW-1:0]     fifo_wr_c;

    dcmb_gate gate_i (
        .dir_in     (cfg_dir_in),
        .ctl_dreq   (ctl_dreq),
        .fifo_empty (fifo_empty),
        .fifo_full  (fifo_full),
        .ready      (ready_c)
    );

    always_comb accept_c = mem_ack & st_q.req;

    dcmb_fx fx_i (
        .dir_in    (cfg_dir_in),
        .role_tgt  (cfg_role_tgt),
        .accept    (accept_c),
        .ctl_pop   (fx_ctl_pop),
        .ctl_push  (fx_ctl_push),
        .fifo_pop  (fx_fifo_pop),
        .fifo_push (fx_fifo_push),
        .cab_ack   (fx_cab),
        .cnt_dec   (fx_dec)
    );

    dcmb_lanes #(.LANE_W(LANE_W), .XLANES(XLANES)) lanes_i (
        .wide          (cfg_wide),
        .ctl_rd_lane   (ctl_rd_lane),
        .fifo_rd_lanes (fifo_rd_lanes),
        .mem_wr_word   (mem_wr_word),
        .rd_word       (rd_word_c),
        .rd_perr       (rd_perr_c),
        .ctl_wr_lane   (ctl_wr_c),
        .fifo_wr_lanes (fifo_wr_c)
    );

    always_comb begin
        st_d           = st_q;
        // request drops after an acknowledge and waits one more cycle
        st_d.req       = ready_c & ~mem_ack & ~st_q.hold;
        st_d.hold      = accept_c;
        st_d.ctl_pop   = fx_ctl_pop;
        st_d.ctl_push  = fx_ctl_push;
        st_d.fifo_pop  = fx_fifo_pop;
        st_d.fifo_push = fx_fifo_push;
        st_d.cab       = fx_cab;
        st_d.dec       = fx_dec;
        if (accept_c && cfg_dir_in) begin
            st_d.rd_word = rd_word_c;
            st_d.perr    = st_q.perr | rd_perr_c;
        end
        if (accept_c && !cfg_dir_in) begin
            st_d.ctl_wr  = ctl_wr_c;
            st_d.fifo_wr = fifo_wr_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        mem_req       = st_q.req;
        mem_rd_word   = st_q.rd_word;
        ctl_wr_lane   = st_q.ctl_wr;
        fifo_wr_lanes = st_q.fifo_wr;
        ctl_pop       = st_q.ctl_pop;
        ctl_push      = st_q.ctl_push;
        fifo_pop      = st_q.fifo_pop;
        fifo_push     = st_q.fifo_push;
        cable_ack     = st_q.cab;
        cnt_dec       = st_q.dec;
        par_err       = st_q.perr;
    end
endmodule

// File: rtl/dcmb_chk.sv
module dcmb_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_dir_in,
    input logic cfg_role_tgt,
    input logic ctl_dreq,
    input logic fifo_empty,
    input logic fifo_full,
    input logic mem_req,
    input logic mem_ack,
    input logic ctl_pop,
    input logic ctl_push,
    input logic fifo_pop,
    input logic fifo_push,
    input logic cable_ack,
    input logic cnt_dec,
    input logic par_err
);
    // R1 R2
    req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> $past(ctl_dreq && (cfg_dir_in ? !fifo_empty : !fifo_full)));

    // R3
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ack && mem_req) |=> !mem_req);

    // R3
    req_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ack && mem_req) |=> ##1 !mem_req);

    // R4 R5
    strobe_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((ctl_pop || fifo_pop) && (ctl_push || fifo_push)));

    // R11
    strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_pop || ctl_push || fifo_pop || fifo_push) |-> $past(mem_ack && mem_req));

    // R7
    cab_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cable_ack |-> ($past(mem_ack && mem_req) && cfg_dir_in && !cfg_role_tgt));

    // R8
    dec_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_dec |-> ($past(mem_ack && mem_req) && cfg_dir_in && cfg_role_tgt));

    // R9
    perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |=> par_err);
endmodule

bind dcmb_top dcmb_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_dir_in   (cfg_dir_in),
    .cfg_role_tgt (cfg_role_tgt),
    .ctl_dreq     (ctl_dreq),
    .fifo_empty   (fifo_empty),
    .fifo_full    (fifo_full),
    .mem_req      (mem_req),
    .mem_ack      (mem_ack),
    .ctl_pop      (ctl_pop),
    .ctl_push     (ctl_push),
    .fifo_pop     (fifo_pop),
    .fifo_push    (fifo_push),
    .cable_ack    (cable_ack),
    .cnt_dec      (cnt_dec),
    .par_err      (par_err)
);

// File: tb/dcmb_top_tb_top.sv
`timescale 1ns/1ps
module dcmb_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wide = 1'b1, cfg_dir_in = 1'b1, cfg_role_tgt = 1'b0;
    logic        ctl_dreq = 1'b0, fifo_empty = 1'b1, fifo_full = 1'b1;
    logic        mem_req, mem_ack = 1'b0;
    logic [31:0] mem_rd_word, mem_wr_word = '0;
    logic [8:0]  ctl_rd_lane = '0, ctl_wr_lane;
    logic        ctl_pop, ctl_push, fifo_pop, fifo_push;
    logic [26:0] fifo_rd_lanes = '0, fifo_wr_lanes;
    logic        cable_ack, cnt_dec, par_err;

    int checks = 0;
    int fails  = 0;
    logic perr_model = 1'b0;

    typedef struct {
        logic        dir_in;
        logic [31:0] word;
        logic [8:0]  ctl;
        logic [26:0] fifo;
        logic        cab;
        logic        dec;
        logic        perr;
    } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    dcmb_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_dir_in(cfg_dir_in),
        .cfg_role_tgt(cfg_role_tgt), .ctl_dreq(ctl_dreq), .fifo_empty(fifo_empty),
        .fifo_full(fifo_full), .mem_req(mem_req), .mem_ack(mem_ack),
        .mem_rd_word(mem_rd_word), .mem_wr_word(mem_wr_word),
        .ctl_rd_lane(ctl_rd_lane), .ctl_wr_lane(ctl_wr_lane), .ctl_pop(ctl_pop),
        .ctl_push(ctl_push), .fifo_rd_lanes(fifo_rd_lanes), .fifo_wr_lanes(fifo_wr_lanes),
        .fifo_pop(fifo_pop), .fifo_push(fifo_push), .cable_ack(cable_ack),
        .cnt_dec(cnt_dec), .par_err(par_err)
    );

    function automatic logic [8:0] lane(input logic [7:0] b, input logic flip);
        return {(~(^b)) ^ flip, b};
    endfunction

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: compares strobed results against the scoreboard
    always @(negedge clk) begin
        if (rst_n && (ctl_pop || ctl_push || fifo_pop || fifo_push || cable_ack || cnt_dec)) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R11 unexpected strobe", {ctl_pop, ctl_push, fifo_pop, fifo_push}, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                if (e.dir_in) begin
                    chk(ctl_pop && fifo_pop && !ctl_push && !fifo_push, "R4 pop strobes",
                        {ctl_pop, ctl_push, fifo_pop, fifo_push}, 4'b1010);
                    chk(mem_rd_word == e.word, "R4/R6 assembled word", mem_rd_word, e.word);
                    chk(par_err == e.perr, "R9 parity flag", par_err, e.perr);
                end else begin
                    chk(ctl_push && fifo_push && !ctl_pop && !fifo_pop, "R5 push strobes",
                        {ctl_pop, ctl_push, fifo_pop, fifo_push}, 4'b0101);
                    chk(ctl_wr_lane == e.ctl, "R5 controller lane", ctl_wr_lane, e.ctl);
                    chk(fifo_wr_lanes == e.fifo, "R5/R6 fifo lanes", fifo_wr_lanes, e.fifo);
                end
                chk(cable_ack == e.cab, "R7 cable ack", cable_ack, e.cab);
                chk(cnt_dec == e.dec, "R8 counter decrement", cnt_dec, e.dec);
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        mem_ack = 1'b0;
        ctl_dreq = 1'b0;
        perr_model = 1'b0;
        repeat (3) @(negedge clk);
        chk(mem_req == 0 && par_err == 0 && mem_rd_word == 0 && ctl_wr_lane == 0 &&
            fifo_wr_lanes == 0 && !ctl_pop && !ctl_push && !fifo_pop && !fifo_push &&
            !cable_ack && !cnt_dec, "R10 reset state", {mem_req, par_err, mem_rd_word}, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // one full word transfer in the current configuration
    task automatic xfer(input logic [31:0] w, input logic [3:0] bad);
        exp_t e;
        logic [8:0] l1, l2;
        // data on both paths
        ctl_rd_lane   = lane(w[7:0], bad[0]);
        fifo_rd_lanes = {lane(w[31:24], bad[3]), lane(w[23:16], bad[2]), lane(w[15:8], bad[1])};
        mem_wr_word   = w;
        // FIFO ready, controller not
        ctl_dreq   = 1'b0;
        fifo_empty = cfg_dir_in ? 1'b0 : 1'b1;
        fifo_full  = cfg_dir_in ? 1'b1 : 1'b0;
        @(negedge clk);
        chk(mem_req == 0, cfg_dir_in ? "R1 no controller request" : "R2 no controller request", mem_req, 0);
        // controller ready, FIFO not (the other flag signals ready)
        ctl_dreq   = 1'b1;
        fifo_empty = cfg_dir_in ? 1'b1 : 1'b0;
        fifo_full  = cfg_dir_in ? 1'b0 : 1'b1;
        @(negedge clk);
        chk(mem_req == 0, cfg_dir_in ? "R1 fifo empty blocks" : "R2 fifo full blocks", mem_req, 0);
        fifo_empty = cfg_dir_in ? 1'b0 : 1'b1;
        fifo_full  = cfg_dir_in ? 1'b1 : 1'b0;
        @(negedge clk);
        chk(mem_req == 1, cfg_dir_in ? "R1 request raised" : "R2 request raised", mem_req, 1);
        // expected result
        e.dir_in = cfg_dir_in;
        e.word   = {cfg_wide ? w[31:16] : 16'h0, w[15:0]};
        perr_model = perr_model | bad[0] | bad[1] | (cfg_wide & (bad[2] | bad[3]));
        e.perr   = perr_model;
        e.ctl    = lane(w[7:0], 1'b0);
        l1       = cfg_wide ? lane(w[23:16], 1'b0) : 9'h0;
        l2       = cfg_wide ? lane(w[31:24], 1'b0) : 9'h0;
        e.fifo   = {l2, l1, lane(w[15:8], 1'b0)};
        e.cab    = cfg_dir_in & ~cfg_role_tgt;
        e.dec    = cfg_dir_in &  cfg_role_tgt;
        sb_q.push_back(e);
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
        chk(mem_req == 0, "R3 low first cycle after ack", mem_req, 0);
        @(negedge clk);
        chk(mem_req == 0, "R3 low second cycle after ack", mem_req, 0);
        @(negedge clk);
        chk(mem_req == 1, "R3 raised again while ready", mem_req, 1);
        ctl_dreq = 1'b0;
        @(negedge clk);
        chk(mem_req == 0, "R1/R2 request follows controller", mem_req, 0);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R11: acknowledge without request
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
        @(negedge clk);
        chk(!ctl_pop && !fifo_pop && !cable_ack && mem_rd_word == 0 && mem_req == 0,
            "R11 stray ack ignored", {ctl_pop, fifo_pop, cable_ack, mem_rd_word}, 0);

        // inbound, initiator, wide: R4 R7
        cfg_dir_in = 1'b1; cfg_role_tgt = 1'b0; cfg_wide = 1'b1;
        xfer(32'hA55A_3C0F, 4'b0000);
        xfer(32'h0123_FF80, 4'b0000);
        // inbound, target: R8
        cfg_role_tgt = 1'b1;
        xfer(32'hDEAD_BEEF, 4'b0000);
        // narrow with bad parity on unused lanes: R6 R9
        cfg_wide = 1'b0;
        xfer(32'h7777_1234, 4'b1100);
        chk(par_err == 0, "R9 unused lanes not checked", par_err, 0);
        // wide with bad controller parity, then a good word: R9 sticky
        cfg_wide = 1'b1; cfg_role_tgt = 1'b0;
        xfer(32'h1111_2222, 4'b0001);
        xfer(32'h3333_4444, 4'b0000);
        chk(par_err == 1, "R9 sticky error", par_err, 1);

        // outbound: R2 R5 R6 R8
        do_reset();
        cfg_dir_in = 1'b0; cfg_role_tgt = 1'b0; cfg_wide = 1'b1;
        xfer(32'h89AB_CDEF, 4'b0000);
        xfer(32'h0000_0001, 4'b0000);
        cfg_role_tgt = 1'b1;
        xfer(32'hFE01_7F80, 4'b0000);
        cfg_wide = 1'b0;
        xfer(32'hFFFF_5AA5, 4'b0000);
        chk(!cable_ack && !cnt_dec, "R8 no side strobe outbound", {cable_ack, cnt_dec}, 0);

        repeat (3) @(negedge clk);
        chk(sb_q.size() == 0, "R4/R5 all words produced", sb_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule